// File: doc/BRIEF.md
# Slope and Offset Calibration Converter

This block turns a raw 16-bit analog-to-digital count into a calibrated reading. The count is multiplied by an unsigned fixed-point slope with eight integer and eight fraction bits, the product is rounded back to whole units, and a signed 16-bit offset is added. The result is clamped to the 16-bit range of the selected channel. A module monitor uses it for four quantities: die temperature, supply voltage, laser bias current and transmit optical power. Only the temperature count is signed.

A host pulses `start` with the count, the per-channel slope and offset, a channel code and a pass-through flag. Two clock edges later `done` pulses for one cycle and `result` carries the reading. `result` holds that value until the next conversion finishes. When the pass-through flag is set, the raw count is returned untouched. This serves parts whose counts are already calibrated in their final units. A start that arrives while a conversion is in flight is dropped.

Top module: `cal_convert`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `done` is 0 and `result` is 0.
- R2: A start accepted at clock edge N gives `done` = 1 for exactly the cycle after edge N+1. `done` is never high on two consecutive cycles.
- R3: `start` sampled one edge after an accepted start is ignored. It produces no extra `done` pulse and does not change `result`.
- R4: For channel codes 1, 2 and 3 (supply, bias, transmit power), `raw` is unsigned. With `bypass` = 0, `result` = floor((raw*slope + 128) / 256) + offset.
- R5: For channel code 0 (temperature), `raw` is read as a two's complement value and the same formula applies.
- R6: `offset` is always a two's complement value, so 0xFFF6 subtracts 10.
- R7: Rounding adds half an output LSB (product bit 7) before dropping the eight fraction bits. Exact halves round upward, toward positive infinity.
- R8: On channels 1 to 3, results below 0 give 0x0000 and results above 65535 give 0xFFFF.
- R9: On channel 0, results below -32768 give 0x8000 and results above 32767 give 0x7FFF.
- R10: With `bypass` = 1, `result` equals `raw`, whatever the slope, offset and channel.
- R11: A slope of 0x0100 with an offset of 0 returns `raw` unchanged on every channel.
- R12: `result` changes only on a cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a conversion when the block is idle |
| chan_sel | input | 2 | 0 temperature (signed), 1 supply, 2 bias, 3 transmit power |
| bypass | input | 1 | 1 returns the raw count unchanged |
| raw | input | 16 | Raw A/D count |
| slope | input | 16 | Unsigned 8.8 fixed-point slope |
| offset | input | 16 | Two's complement offset in output LSB units |
| result | output | 16 | Calibrated reading, held between conversions |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The timing properties assume that `start`, `chan_sel`, `bypass`, `raw`, `slope` and `offset` are held at known values from reset onward. They also assume the operands stay stable on the cycle a start is sampled, so that a value taken two cycles back is the operand the conversion used.

The bench meets this in two ways. It drives every input to zero from time zero, and it changes inputs only on the falling edge. It also leaves at least one idle cycle after each `done` before issuing the next start. The only exception is the deliberate back-to-back start used to probe the busy window.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int CH_W = 2;

  typedef enum logic [CH_W-1:0] {
    CH_TEMP  = 2'd0,
    CH_VCC   = 2'd1,
    CH_BIAS  = 2'd2,
    CH_TXPWR = 2'd3
  } cal_chan_e;

  // Only the temperature channel carries a signed raw count.
  function automatic logic chan_is_signed(input logic [CH_W-1:0] ch);
    return ch == CH_TEMP;
  endfunction
endpackage

// File: rtl/cal_operand.sv
module cal_operand #(
  parameter int RAW_W   = 16,
  parameter int SLOPE_W = 16,
  parameter int OP_W    = 34
) (
  input  logic [RAW_W-1:0]       raw,
  input  logic [SLOPE_W-1:0]     slope,
  input  logic                   is_signed,
  output logic signed [OP_W-1:0] raw_x,
  output logic signed [OP_W-1:0] slope_x
);
  localparam int RAW_PAD   = OP_W - RAW_W;
  localparam int SLOPE_PAD = OP_W - SLOPE_W;

  logic pad_bit;

  // Sign fill only for a signed channel; zero fill otherwise.
  assign pad_bit = is_signed & raw[RAW_W-1];
  assign raw_x   = {{RAW_PAD{pad_bit}}, raw};
  // The slope is always a positive magnitude.
  assign slope_x = {{SLOPE_PAD{1'b0}}, slope};
endmodule

// File: rtl/cal_mult.sv
module cal_mult #(
  parameter int RAW_W = 16,
  parameter int OFS_W = 16,
  parameter int OP_W  = 34
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic signed [OP_W-1:0] raw_x,
  input  logic signed [OP_W-1:0] slope_x,
  input  logic [OFS_W-1:0]       ofs_in,
  input  logic [RAW_W-1:0]       raw_in,
  input  logic                   signed_in,
  input  logic                   bypass_in,
  output logic                   valid,
  output logic signed [OP_W-1:0] prod,
  output logic [OFS_W-1:0]       ofs_q,
  output logic [RAW_W-1:0]       raw_q,
  output logic                   signed_q,
  output logic                   bypass_q
);
  logic signed [OP_W-1:0] prod_d;

  assign prod_d = raw_x * slope_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      prod     <= '0;
      ofs_q    <= '0;
      raw_q    <= '0;
      signed_q <= 1'b0;
      bypass_q <= 1'b0;
    end else begin
      valid <= load;
      if (load) begin
        prod     <= prod_d;
        ofs_q    <= ofs_in;
        raw_q    <= raw_in;
        signed_q <= signed_in;
        bypass_q <= bypass_in;
      end
    end
  end
endmodule

// File: rtl/cal_sat.sv
module cal_sat #(
  parameter int SUM_W = 27,
  parameter int OUT_W = 16
) (
  input  logic signed [SUM_W-1:0] sum,
  input  logic                    is_signed,
  output logic [OUT_W-1:0]        sat
);
  localparam logic signed [SUM_W-1:0] SMAX = SUM_W'((64'd1 << (OUT_W-1)) - 64'd1);
  localparam logic signed [SUM_W-1:0] SMIN = -SMAX - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] UMAX = SUM_W'((64'd1 << OUT_W) - 64'd1);

  always_comb begin
    if (is_signed) begin
      if (sum > SMAX)      sat = SMAX[OUT_W-1:0];
      else if (sum < SMIN) sat = SMIN[OUT_W-1:0];
      else                 sat = sum[OUT_W-1:0];
    end else begin
      if (sum > UMAX)               sat = UMAX[OUT_W-1:0];
      else if (sum < SUM_W'(0))     sat = '0;
      else                          sat = sum[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/cal_finish.sv
module cal_finish #(
  parameter int RAW_W    = 16,
  parameter int OFS_W    = 16,
  parameter int OUT_W    = 16,
  parameter int FRAC_W   = 8,
  parameter int OP_W     = 34,
  parameter bit ROUND_EN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [OP_W-1:0] prod,
  input  logic [OFS_W-1:0]       ofs,
  input  logic [RAW_W-1:0]       raw,
  input  logic                   is_signed,
  input  logic                   bypass,
  output logic [OUT_W-1:0]       result,
  output logic                   done
);
  localparam int SHIFT_W = OP_W - FRAC_W;
  localparam int SUM_W   = SHIFT_W + 1;

  logic signed [OP_W-1:0]    rnd_sum;
  logic signed [SHIFT_W-1:0] scaled;
  logic signed [SUM_W-1:0]   total;
  logic [OUT_W-1:0]          clamped;
  logic [OUT_W-1:0]          next_res;

  generate
    if (ROUND_EN) begin : g_round
      // Half an output LSB sits at the top fraction bit.
      assign rnd_sum = prod + OP_W'(64'd1 << (FRAC_W-1));
    end else begin : g_trunc
      assign rnd_sum = prod;
    end
  endgenerate

  // Dropping the fraction bits is a floor for two's complement values.
  assign scaled = rnd_sum[OP_W-1:FRAC_W];
  assign total  = $signed({scaled[SHIFT_W-1], scaled})
                + $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});

  cal_sat #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_sat (
    .sum       (total),
    .is_signed (is_signed),
    .sat       (clamped)
  );

  assign next_res = bypass ? OUT_W'(raw) : clamped;

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/cal_convert.sv
module cal_convert
  import cal_pkg::*;
#(
  parameter int RAW_W    = 16,
  parameter int SLOPE_W  = 16,
  parameter int FRAC_W   = 8,
  parameter int OFS_W    = 16,
  parameter int OUT_W    = 16,
  parameter bit ROUND_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             bypass,
  input  logic [RAW_W-1:0] raw,
  input  logic [SLOPE_W-1:0] slope,
  input  logic [OFS_W-1:0] offset,
  output logic [OUT_W-1:0] result,
  output logic             done
);
  localparam int OP_W = RAW_W + SLOPE_W + 2;

  logic                   busy;
  logic                   accept;
  logic                   sel_signed;
  logic signed [OP_W-1:0] raw_x;
  logic signed [OP_W-1:0] slope_x;
  logic                   s1_valid;
  logic signed [OP_W-1:0] s1_prod;
  logic [OFS_W-1:0]       s1_ofs;
  logic [RAW_W-1:0]       s1_raw;
  logic                   s1_signed;
  logic                   s1_bypass;

  // One conversion in flight at a time; the pipe has one busy stage.
  assign busy       = s1_valid;
  assign accept     = start & ~busy;
  assign sel_signed = chan_is_signed(chan_sel);

  cal_operand #(.RAW_W(RAW_W), .SLOPE_W(SLOPE_W), .OP_W(OP_W)) u_opnd (
    .raw       (raw),
    .slope     (slope),
    .is_signed (sel_signed),
    .raw_x     (raw_x),
    .slope_x   (slope_x)
  );

  cal_mult #(.RAW_W(RAW_W), .OFS_W(OFS_W), .OP_W(OP_W)) u_mult (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .raw_x     (raw_x),
    .slope_x   (slope_x),
    .ofs_in    (offset),
    .raw_in    (raw),
    .signed_in (sel_signed),
    .bypass_in (bypass),
    .valid     (s1_valid),
    .prod      (s1_prod),
    .ofs_q     (s1_ofs),
    .raw_q     (s1_raw),
    .signed_q  (s1_signed),
    .bypass_q  (s1_bypass)
  );

  cal_finish #(
    .RAW_W(RAW_W), .OFS_W(OFS_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W),
    .OP_W(OP_W), .ROUND_EN(ROUND_EN)
  ) u_fin (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s1_valid),
    .prod      (s1_prod),
    .ofs       (s1_ofs),
    .raw       (s1_raw),
    .is_signed (s1_signed),
    .bypass    (s1_bypass),
    .result    (result),
    .done      (done)
  );
endmodule

// File: rtl/cal_convert_chk.sv
module cal_convert_chk #(
  parameter int RAW_W   = 16,
  parameter int SLOPE_W = 16,
  parameter int OFS_W   = 16,
  parameter int OUT_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [1:0]         chan_sel,
  input logic               bypass,
  input logic [RAW_W-1:0]   raw,
  input logic [SLOPE_W-1:0] slope,
  input logic [OFS_W-1:0]   offset,
  input logic [OUT_W-1:0]   result,
  input logic               done
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!done && result == '0));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 2));

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R10
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(bypass, 2)) |-> result == OUT_W'($past(raw, 2)));

  // R11
  identity_cal_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(slope, 2) == SLOPE_W'(256) && $past(offset, 2) == '0)
      |-> result == OUT_W'($past(raw, 2)));
endmodule

bind cal_convert cal_convert_chk #(
  .RAW_W(RAW_W), .SLOPE_W(SLOPE_W), .OFS_W(OFS_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .chan_sel(chan_sel), .bypass(bypass),
  .raw(raw), .slope(slope), .offset(offset), .result(result), .done(done)
);

// File: tb/cal_convert_test.sv
module cal_convert_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  chan_sel = '0;
  logic        bypass = 1'b0;
  logic [15:0] raw = '0;
  logic [15:0] slope = '0;
  logic [15:0] offset = '0;
  logic [15:0] result;
  logic        done;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cal_convert uut (
    .clk(clk), .rst(rst), .start(start), .chan_sel(chan_sel), .bypass(bypass),
    .raw(raw), .slope(slope), .offset(offset), .result(result), .done(done)
  );

  function automatic logic [15:0] model(input int ch, input bit byp,
                                        input logic [15:0] r, input logic [15:0] s,
                                        input logic [15:0] o);
    longint rv, p, q, v;
    if (byp) return r;
    rv = (ch == 0) ? longint'($signed(r)) : longint'(r);
    p  = rv * longint'(s);
    q  = (p + 128) >>> 8;
    v  = q + longint'($signed(o));
    if (ch == 0) begin
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
    end else begin
      if (v > 65535) v = 65535;
      if (v < 0) v = 0;
    end
    return v[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Start at a falling edge; sampled on the next rise; result read after the following rise.
  task automatic run(input string req, input int ch, input bit byp,
                     input logic [15:0] r, input logic [15:0] s, input logic [15:0] o);
    chan_sel = 2'(ch); bypass = byp; raw = r; slope = s; offset = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " busy"}, {31'd0, done}, 32'd0);
    @(negedge clk);
    check({req, " done"}, {31'd0, done}, 32'd1);
    check(req, {16'd0, result}, {16'd0, model(ch, byp, r, s, o)});
    @(negedge clk);
    check({req, " done clear"}, {31'd0, done}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    logic [15:0] raws [10];
    logic [15:0] slps [7];
    logic [15:0] ofss [6];
    logic [15:0] keep;
    raws = '{16'h0000, 16'h0001, 16'h0003, 16'h007F, 16'h0080, 16'h1234,
             16'h7FFF, 16'h8000, 16'hFFFD, 16'hFFFF};
    slps = '{16'h0001, 16'h007F, 16'h0080, 16'h0100, 16'h0180, 16'h0200, 16'hFFFF};
    ofss = '{16'h0000, 16'h0001, 16'hFFF6, 16'h7FFF, 16'h8000, 16'hFFFF};

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done in reset", {31'd0, done}, 32'd0);
    check("R1 result in reset", {16'd0, result}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", {31'd0, done}, 32'd0);
    check("R1 result after reset", {16'd0, result}, 32'd0);

    // R7 rounding corners
    run("R7 half rounds up", 1, 0, 16'd1, 16'h0080, 16'h0000);
    run("R7 1.5 rounds up", 1, 0, 16'd3, 16'h0080, 16'h0000);
    run("R7 below half rounds down", 1, 0, 16'd1, 16'h007F, 16'h0000);
    run("R7 R5 negative half", 0, 0, 16'hFFFD, 16'h0080, 16'h0000);
    // R6 signed offset
    run("R6 negative offset", 2, 0, 16'd100, 16'h0100, 16'hFFF6);
    // R8 unsigned clamps
    run("R8 clamp high", 3, 0, 16'hFFFF, 16'h0200, 16'h0000);
    run("R8 clamp low", 1, 0, 16'd2, 16'h0100, 16'hFFFB);
    // R9 signed clamps
    run("R9 clamp high", 0, 0, 16'h7FFF, 16'h0200, 16'h0000);
    run("R9 clamp low", 0, 0, 16'h8000, 16'h0200, 16'h0000);
    // R11 identity
    run("R11 identity temp", 0, 0, 16'hFF38, 16'h0100, 16'h0000);
    run("R11 identity bias", 2, 0, 16'hBEEF, 16'h0100, 16'h0000);
    // R10 bypass ignores slope and offset
    run("R10 bypass", 1, 1, 16'h4321, 16'h0300, 16'h1111);
    run("R10 bypass temp", 0, 1, 16'h8001, 16'hFFFF, 16'h8000);

    // R3: back-to-back start ignored; R12 result held
    chan_sel = 2'd1; bypass = 1'b0; raw = 16'd10; slope = 16'h0100; offset = 16'd0;
    start = 1'b1;
    @(negedge clk);
    raw = 16'd999;
    @(negedge clk);
    start = 1'b0;
    check("R3 first done", {31'd0, done}, 32'd1);
    check("R3 first result", {16'd0, result}, 32'd10);
    keep = result;
    @(negedge clk);
    check("R3 no second done", {31'd0, done}, 32'd0);
    check("R3 R12 result unchanged", {16'd0, result}, {16'd0, keep});
    repeat (3) begin
      raw = raw + 16'd7;
      @(negedge clk);
      check("R12 hold while idle", {16'd0, result}, {16'd0, keep});
    end

    // Sweep: R4 unsigned channels, R5 temperature, R8/R9 via clamps inside
    for (int ch = 0; ch < 4; ch++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 7; j++)
          for (int k = 0; k < 6; k++)
            run(ch == 0 ? "R5 R9 sweep" : "R4 R8 sweep", ch, 0, raws[i], slps[j], ofss[k]);
    // R10 sweep of pass-through
    for (int ch = 0; ch < 4; ch++)
      for (int i = 0; i < 10; i++)
        run("R10 sweep", ch, 1, raws[i], slps[i % 7], ofss[i % 6]);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule